// File: doc/BRIEF.md
# Physical Register Occupancy Tracker

This block keeps a running count of how many physical registers are held in each of several rename register files while instructions pass through register renaming. A small per-architectural-register table says which file owns the register and how many physical entries one definition of it costs. A separate table holds the capacity of each file. File index 0 is an aggregate file: every allocation and every release is charged to it, on top of any charge to the owning file. A register whose owning index is 0 has no dedicated file and is charged to the aggregate file only. A capacity of zero means that the file is unbounded.

The rename stage sends at most one allocate and one release per cycle. Each carries an architectural register number and three qualifiers. These mark a zero idiom, an eliminated move, or a partial write that is merged into its enclosing register without clearing the upper bits. Any of the three means that no physical register is taken or given back. The rename stage also sends an availability query for up to four destinations. The block answers it in the same cycle with one stall bit per file, so rename can hold a group that would not fit. Both tables are loaded through a simple write port.

Top module: `phys_reg_occupancy`

## Requirements
- R1: After reset every occupancy count is 0 and the error flag is low. Every register maps to file 0 with cost 1. Every capacity is 0, so no stall bit is set.
- R2: An allocate of a register mapped to file f (f > 0) with cost C raises both count f and count 0 by C, visible one cycle later.
- R3: An allocate or release of a register mapped to file 0 changes count 0 only.
- R4: An allocate or release that has the zero, eliminated or merged qualifier set changes no count.
- R5: A release of a register with cost C lowers the owning count and count 0 by C, one cycle later.
- R6: An allocate and a release in the same cycle change each count by their net difference. The allocate is counted first, so a release that the same-cycle allocate covers is not an underflow.
- R7: A net decrease below zero leaves that count at 0 and sets the error flag. The flag stays set until reset.
- R8: A file whose capacity is 0 never raises its stall bit.
- R9: For each file the query adds the costs of the valid slots that map to it; every valid slot counts toward file 0. Slots whose valid bit is clear contribute nothing. Stall bit f is set when the count plus this sum is greater than the capacity. A sum of 0 never stalls.
- R10: When the summed request for a file is larger than its capacity, the sum is first reduced to the capacity. The stall bit is then set only if the file's count is above 0.
- R11: The stall bits depend combinationally on the query inputs and the current counts and tables. They change in the same cycle as the query.
- R12: Map and capacity writes take effect at the next clock edge. An allocate, release or query in the same cycle as a write still sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_map_we | input | 1 | Write one register-map entry |
| cfg_map_reg | input | 5 | Architectural register being mapped |
| cfg_map_file | input | 2 | Owning file index (0 = aggregate only) |
| cfg_map_cost | input | 3 | Physical entries per definition |
| cfg_cap_we | input | 1 | Write one file capacity |
| cfg_cap_file | input | 2 | File whose capacity is written |
| cfg_cap_val | input | 8 | Capacity value (0 = unbounded) |
| alloc_valid | input | 1 | Allocate request |
| alloc_reg | input | 5 | Architectural destination being allocated |
| alloc_zero | input | 1 | Allocate is a zero idiom |
| alloc_elim | input | 1 | Allocate is an eliminated move |
| alloc_merge | input | 1 | Allocate is a merged partial write |
| free_valid | input | 1 | Release request |
| free_reg | input | 5 | Architectural register being released |
| free_zero | input | 1 | Release of a zero-idiom write |
| free_elim | input | 1 | Release of an eliminated move |
| free_merge | input | 1 | Release of a merged partial write |
| q_valid | input | 4 | Valid bit per query slot |
| q_regs | input | 20 | Query registers, slot n at bits 5n+4..5n |
| stall | output | 4 | Stall bit per file, bit f for file f |
| used_flat | output | 32 | Occupancy counts, file f at bits 8f+7..8f |
| count_err | output | 1 | Sticky underflow flag |

## Verification
A wrong count shows up at once, on used_flat one cycle after the edge that updated it. If it does not, it appears in the stall bits as soon as a query touches that file. So the reference model compares every count on every cycle. A wrong map or capacity entry stays hidden until that register is allocated or that file is queried. The sequence therefore exercises each entry it writes with both an allocate and a query near the capacity limit. It also checks the stall bits in the same half-cycle that the query is applied, and checks the clamped case both with an empty file and with an occupied one.

// File: rtl/prt_pkg.sv
package prt_pkg;

   typedef struct packed {
      logic zero;
      logic elim;
      logic merge;
   } wr_kind_t;

   function automatic logic kind_consumes(wr_kind_t k);
      return !(k.zero | k.elim | k.merge);
   endfunction

endpackage

// File: rtl/prt_map_table.sv
module prt_map_table #(
   parameter int NUM_AREGS = 32,
   parameter int FILE_W    = 2,
   parameter int COST_W    = 3,
   parameter int NUM_Q     = 4,
   localparam int AREG_W   = $clog2(NUM_AREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AREG_W-1:0] wr_reg,
   input  logic [FILE_W-1:0] wr_file,
   input  logic [COST_W-1:0] wr_cost,
   input  logic [AREG_W-1:0] alloc_reg,
   input  logic [AREG_W-1:0] free_reg,
   input  logic [AREG_W-1:0] q_reg  [NUM_Q],
   output logic [FILE_W-1:0] alloc_file,
   output logic [COST_W-1:0] alloc_cost,
   output logic [FILE_W-1:0] free_file,
   output logic [COST_W-1:0] free_cost,
   output logic [FILE_W-1:0] q_file [NUM_Q],
   output logic [COST_W-1:0] q_cost [NUM_Q]
);

   logic [FILE_W-1:0] file_q [NUM_AREGS];
   logic [COST_W-1:0] cost_q [NUM_AREGS];

   // reset: no dedicated file, one physical entry per definition
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_AREGS; i++) begin
            file_q[i] <= '0;
            cost_q[i] <= COST_W'(1);
         end
      end else if (wr_en) begin
         file_q[wr_reg] <= wr_file;
         cost_q[wr_reg] <= wr_cost;
      end
   end

   assign alloc_file = file_q[alloc_reg];
   assign alloc_cost = cost_q[alloc_reg];
   assign free_file  = file_q[free_reg];
   assign free_cost  = cost_q[free_reg];

   for (genvar q = 0; q < NUM_Q; q++) begin : g_qport
      assign q_file[q] = file_q[q_reg[q]];
      assign q_cost[q] = cost_q[q_reg[q]];
   end

endmodule

// File: rtl/prt_occ_counter.sv
module prt_occ_counter #(
   parameter int COST_W = 3,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COST_W-1:0] add_amt,
   input  logic [COST_W-1:0] sub_amt,
   output logic [CNT_W-1:0]  used,
   output logic              underflow
);

   localparam int SUM_W = CNT_W + 1;
   localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((64'd1 << CNT_W) - 64'd1);

   logic [SUM_W-1:0] plus;
   logic [SUM_W-1:0] diff;
   logic [CNT_W-1:0] nxt;

   // the allocation is applied before the release within one cycle
   assign plus      = {1'b0, used} + SUM_W'(add_amt);
   assign underflow = plus < SUM_W'(sub_amt);
   assign diff      = plus - SUM_W'(sub_amt);

   always_comb begin
      if (underflow)          nxt = '0;
      else if (diff > CNT_MAX) nxt = CNT_MAX[CNT_W-1:0];
      else                    nxt = diff[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) used <= '0;
      else        used <= nxt;
   end

endmodule

// File: rtl/prt_stall_calc.sv
module prt_stall_calc #(
   parameter int NUM_FILES = 4,
   parameter int NUM_Q     = 4,
   parameter int FILE_W    = 2,
   parameter int COST_W    = 3,
   parameter int CNT_W     = 8
) (
   input  logic [NUM_Q-1:0]           q_valid,
   input  logic [FILE_W-1:0]          q_file [NUM_Q],
   input  logic [COST_W-1:0]          q_cost [NUM_Q],
   input  logic [NUM_FILES*CNT_W-1:0] used_flat,
   input  logic [NUM_FILES*CNT_W-1:0] cap_flat,
   output logic [NUM_FILES-1:0]       stall
);

   localparam int NEED_W = COST_W + $clog2(NUM_Q + 1);
   localparam int CMP_W  = ((NEED_W > CNT_W) ? NEED_W : CNT_W) + 1;

   for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
      logic [NUM_Q-1:0]  hit;
      logic [NEED_W-1:0] need;
      logic [CMP_W-1:0]  cap_e;
      logic [CMP_W-1:0]  need_e;
      logic [CMP_W-1:0]  need_c;
      logic [CNT_W-1:0]  cap_f;

      if (f == 0) begin : g_agg
         assign hit = q_valid;
      end else begin : g_ded
         for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
            assign hit[q] = q_valid[q] && (q_file[q] == FILE_W'(f));
         end
      end

      always_comb begin
         need = '0;
         for (int q = 0; q < NUM_Q; q++)
            if (hit[q]) need = need + NEED_W'(q_cost[q]);
      end

      assign cap_f  = cap_flat[f*CNT_W +: CNT_W];
      assign cap_e  = CMP_W'(cap_f);
      assign need_e = CMP_W'(need);
      // a request larger than the whole file is trimmed to the file size
      assign need_c = (need_e > cap_e) ? cap_e : need_e;

      assign stall[f] = (cap_f != '0) && (need != '0) &&
                        ((CMP_W'(used_flat[f*CNT_W +: CNT_W]) + need_c) > cap_e);
   end

endmodule

// File: rtl/phys_reg_occupancy.sv
module phys_reg_occupancy
   import prt_pkg::*;
#(
   parameter int NUM_FILES = 4,
   parameter int NUM_AREGS = 32,
   parameter int NUM_Q     = 4,
   parameter int COST_W    = 3,
   parameter int CNT_W     = 8,
   localparam int FILE_W   = $clog2(NUM_FILES),
   localparam int AREG_W   = $clog2(NUM_AREGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_map_we,
   input  logic [AREG_W-1:0]          cfg_map_reg,
   input  logic [FILE_W-1:0]          cfg_map_file,
   input  logic [COST_W-1:0]          cfg_map_cost,
   input  logic                       cfg_cap_we,
   input  logic [FILE_W-1:0]          cfg_cap_file,
   input  logic [CNT_W-1:0]           cfg_cap_val,
   input  logic                       alloc_valid,
   input  logic [AREG_W-1:0]          alloc_reg,
   input  logic                       alloc_zero,
   input  logic                       alloc_elim,
   input  logic                       alloc_merge,
   input  logic                       free_valid,
   input  logic [AREG_W-1:0]          free_reg,
   input  logic                       free_zero,
   input  logic                       free_elim,
   input  logic                       free_merge,
   input  logic [NUM_Q-1:0]           q_valid,
   input  logic [NUM_Q*AREG_W-1:0]    q_regs,
   output logic [NUM_FILES-1:0]       stall,
   output logic [NUM_FILES*CNT_W-1:0] used_flat,
   output logic                       count_err
);

   if (NUM_FILES < 2) begin : g_chk_files
      $error("phys_reg_occupancy: NUM_FILES must be at least 2");
   end
   if (NUM_Q < 1) begin : g_chk_q
      $error("phys_reg_occupancy: NUM_Q must be at least 1");
   end
   if (CNT_W <= COST_W) begin : g_chk_cnt
      $error("phys_reg_occupancy: CNT_W must exceed COST_W");
   end
   if (NUM_AREGS < 2) begin : g_chk_aregs
      $error("phys_reg_occupancy: NUM_AREGS must be at least 2");
   end

   wr_kind_t alloc_kind, free_kind;
   logic     alloc_go, free_go;

   assign alloc_kind = '{zero: alloc_zero, elim: alloc_elim, merge: alloc_merge};
   assign free_kind  = '{zero: free_zero,  elim: free_elim,  merge: free_merge};
   assign alloc_go   = alloc_valid && kind_consumes(alloc_kind);
   assign free_go    = free_valid  && kind_consumes(free_kind);

   // ---------------- register map ----------------
   logic [AREG_W-1:0] q_reg  [NUM_Q];
   logic [FILE_W-1:0] q_file [NUM_Q];
   logic [COST_W-1:0] q_cost [NUM_Q];
   logic [FILE_W-1:0] alloc_file, free_file;
   logic [COST_W-1:0] alloc_cost, free_cost;

   for (genvar q = 0; q < NUM_Q; q++) begin : g_qsplit
      assign q_reg[q] = q_regs[q*AREG_W +: AREG_W];
   end

   prt_map_table #(
      .NUM_AREGS (NUM_AREGS),
      .FILE_W    (FILE_W),
      .COST_W    (COST_W),
      .NUM_Q     (NUM_Q)
   ) i_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_map_we),
      .wr_reg     (cfg_map_reg),
      .wr_file    (cfg_map_file),
      .wr_cost    (cfg_map_cost),
      .alloc_reg  (alloc_reg),
      .free_reg   (free_reg),
      .q_reg      (q_reg),
      .alloc_file (alloc_file),
      .alloc_cost (alloc_cost),
      .free_file  (free_file),
      .free_cost  (free_cost),
      .q_file     (q_file),
      .q_cost     (q_cost)
   );

   // ---------------- capacities ----------------
   logic [CNT_W-1:0]           cap_q [NUM_FILES];
   logic [NUM_FILES*CNT_W-1:0] cap_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FILES; i++) cap_q[i] <= '0;
      end else if (cfg_cap_we) begin
         for (int i = 0; i < NUM_FILES; i++)
            if (cfg_cap_file == FILE_W'(i)) cap_q[i] <= cfg_cap_val;
      end
   end

   // ---------------- per-file counters ----------------
   logic [NUM_FILES-1:0] uflow;

   for (genvar f = 0; f < NUM_FILES; f++) begin : g_cnt
      logic [COST_W-1:0] add_amt, sub_amt;

      if (f == 0) begin : g_agg
         assign add_amt = alloc_go ? alloc_cost : '0;
         assign sub_amt = free_go  ? free_cost  : '0;
      end else begin : g_ded
         assign add_amt = (alloc_go && alloc_file == FILE_W'(f)) ? alloc_cost : '0;
         assign sub_amt = (free_go  && free_file  == FILE_W'(f)) ? free_cost  : '0;
      end

      prt_occ_counter #(
         .COST_W (COST_W),
         .CNT_W  (CNT_W)
      ) i_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .add_amt   (add_amt),
         .sub_amt   (sub_amt),
         .used      (used_flat[f*CNT_W +: CNT_W]),
         .underflow (uflow[f])
      );

      assign cap_flat[f*CNT_W +: CNT_W] = cap_q[f];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_err <= 1'b0;
      else        count_err <= count_err | (|uflow);
   end

   // ---------------- availability ----------------
   prt_stall_calc #(
      .NUM_FILES (NUM_FILES),
      .NUM_Q     (NUM_Q),
      .FILE_W    (FILE_W),
      .COST_W    (COST_W),
      .CNT_W     (CNT_W)
   ) i_stall (
      .q_valid   (q_valid),
      .q_file    (q_file),
      .q_cost    (q_cost),
      .used_flat (used_flat),
      .cap_flat  (cap_flat),
      .stall     (stall)
   );

endmodule

// File: rtl/phys_reg_occupancy_chk.sv
module phys_reg_occupancy_chk #(
   parameter int NUM_FILES = 4,
   parameter int NUM_Q     = 4,
   parameter int CNT_W     = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       alloc_valid,
   input logic                       alloc_zero,
   input logic                       alloc_elim,
   input logic                       alloc_merge,
   input logic                       free_valid,
   input logic                       free_zero,
   input logic                       free_elim,
   input logic                       free_merge,
   input logic [NUM_Q-1:0]           q_valid,
   input logic [NUM_FILES-1:0]       stall,
   input logic [NUM_FILES*CNT_W-1:0] used_flat,
   input logic [NUM_FILES*CNT_W-1:0] cap_flat,
   input logic                       count_err
);

   // R4: requests that consume nothing leave every count untouched
   assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((!alloc_valid || alloc_zero || alloc_elim || alloc_merge) &&
       (!free_valid  || free_zero  || free_elim  || free_merge))
      |=> $stable(used_flat));

   // R7: the underflow flag never clears without reset
   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count_err |=> count_err);

   // R9: an empty query raises no stall
   assert_idle_query_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid == '0) |-> (stall == '0));

   for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
      // R8: unbounded files never stall
      assert_unbounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_flat[f*CNT_W +: CNT_W] == '0) |-> !stall[f]);

      if (f > 0) begin : g_ded
         // R2: the aggregate count covers every dedicated file while no underflow occurred
         assert_aggregate_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !count_err |-> (used_flat[CNT_W-1:0] >= used_flat[f*CNT_W +: CNT_W]));
      end
   end

endmodule

bind phys_reg_occupancy phys_reg_occupancy_chk #(
   .NUM_FILES (NUM_FILES),
   .NUM_Q     (NUM_Q),
   .CNT_W     (CNT_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_valid (alloc_valid),
   .alloc_zero  (alloc_zero),
   .alloc_elim  (alloc_elim),
   .alloc_merge (alloc_merge),
   .free_valid  (free_valid),
   .free_zero   (free_zero),
   .free_elim   (free_elim),
   .free_merge  (free_merge),
   .q_valid     (q_valid),
   .stall       (stall),
   .used_flat   (used_flat),
   .cap_flat    (cap_flat),
   .count_err   (count_err)
);

// File: tb/test_phys_reg_occupancy.sv
module test_phys_reg_occupancy;

   localparam int NF = 4;
   localparam int NA = 32;
   localparam int NQ = 4;
   localparam int CW = 3;
   localparam int UW = 8;
   localparam int UMAX = 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_map_we = 0; logic [4:0] cfg_map_reg = 0; logic [1:0] cfg_map_file = 0; logic [2:0] cfg_map_cost = 0;
   logic cfg_cap_we = 0; logic [1:0] cfg_cap_file = 0; logic [7:0] cfg_cap_val = 0;
   logic alloc_valid = 0; logic [4:0] alloc_reg = 0; logic alloc_zero = 0, alloc_elim = 0, alloc_merge = 0;
   logic free_valid = 0;  logic [4:0] free_reg = 0;  logic free_zero = 0,  free_elim = 0,  free_merge = 0;
   logic [NQ-1:0] q_valid = 0;
   logic [NQ*5-1:0] q_regs = 0;
   logic [NF-1:0] stall;
   logic [NF*UW-1:0] used_flat;
   logic count_err;

   always #2 clk = ~clk;   // 250 MHz

   phys_reg_occupancy i_phys_reg_occupancy (
      .clk, .rst_n,
      .cfg_map_we, .cfg_map_reg, .cfg_map_file, .cfg_map_cost,
      .cfg_cap_we, .cfg_cap_file, .cfg_cap_val,
      .alloc_valid, .alloc_reg, .alloc_zero, .alloc_elim, .alloc_merge,
      .free_valid, .free_reg, .free_zero, .free_elim, .free_merge,
      .q_valid, .q_regs, .stall, .used_flat, .count_err
   );

   // ---------------- reference model ----------------
   int  used_m [NF];
   int  cap_m  [NF];
   int  mfile  [NA];
   int  mcost  [NA];
   bit  err_m = 0;

   initial begin
      for (int i = 0; i < NF; i++) begin used_m[i] = 0; cap_m[i] = 0; end
      for (int i = 0; i < NA; i++) begin mfile[i] = 0; mcost[i] = 1; end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NF; i++) begin used_m[i] = 0; cap_m[i] = 0; end
         for (int i = 0; i < NA; i++) begin mfile[i] = 0; mcost[i] = 1; end
         err_m = 0;
      end else begin
         bit ag, fg;
         ag = alloc_valid && !(alloc_zero || alloc_elim || alloc_merge);
         fg = free_valid  && !(free_zero  || free_elim  || free_merge);
         for (int f = 0; f < NF; f++) begin
            int a, d, nv;
            a = (ag && (f == 0 || mfile[alloc_reg] == f)) ? mcost[alloc_reg] : 0;
            d = (fg && (f == 0 || mfile[free_reg]  == f)) ? mcost[free_reg]  : 0;
            nv = used_m[f] + a - d;
            if (nv < 0) begin nv = 0; err_m = 1; end
            else if (nv > UMAX) nv = UMAX;
            used_m[f] = nv;
         end
         if (cfg_map_we) begin mfile[cfg_map_reg] = cfg_map_file; mcost[cfg_map_reg] = cfg_map_cost; end
         if (cfg_cap_we) cap_m[cfg_cap_file] = cfg_cap_val;
      end
   end

   function automatic bit exp_stall(int f);
      int need;
      need = 0;
      for (int q = 0; q < NQ; q++) begin
         int r;
         r = q_regs[q*5 +: 5];
         if (q_valid[q] && (f == 0 || mfile[r] == f)) need += mcost[r];
      end
      if (cap_m[f] == 0 || need == 0) return 0;
      if (need > cap_m[f]) need = cap_m[f];
      return (used_m[f] + need) > cap_m[f];
   endfunction

   // ---------------- checking ----------------
   int nchecks = 0;
   int nfails  = 0;
   string cur_req = "R1";

   task automatic check(string req, string what, int act, int exp);
      nchecks++;
      if (act != exp) begin
         nfails++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_stall(string req);
      for (int f = 0; f < NF; f++)
         check(req, $sformatf("stall[%0d]", f), int'(stall[f]), int'(exp_stall(f)));
   endtask

   task automatic compare_all();
      for (int f = 0; f < NF; f++)
         check(cur_req, $sformatf("used[%0d]", f), int'(used_flat[f*UW +: UW]), used_m[f]);
      check(cur_req, "count_err", int'(count_err), int'(err_m));
      check_stall(cur_req);
   endtask

   // inputs are changed just after a falling edge; R11: stall checked in the same half cycle
   task automatic cycle();
      #1 check_stall("R11");
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      cfg_map_we = 0; cfg_cap_we = 0;
      alloc_valid = 0; alloc_zero = 0; alloc_elim = 0; alloc_merge = 0;
      free_valid = 0;  free_zero = 0;  free_elim = 0;  free_merge = 0;
      q_valid = 0;
   endtask

   task automatic map_reg(int r, int f, int c);
      cfg_map_we = 1; cfg_map_reg = 5'(r); cfg_map_file = 2'(f); cfg_map_cost = 3'(c);
      cycle(); idle();
   endtask

   task automatic set_cap(int f, int v);
      cfg_cap_we = 1; cfg_cap_file = 2'(f); cfg_cap_val = 8'(v);
      cycle(); idle();
   endtask

   task automatic alloc(int r, bit z, bit e, bit m);
      alloc_valid = 1; alloc_reg = 5'(r); alloc_zero = z; alloc_elim = e; alloc_merge = m;
      cycle(); idle();
   endtask

   task automatic release_reg(int r, bit z, bit e, bit m);
      free_valid = 1; free_reg = 5'(r); free_zero = z; free_elim = e; free_merge = m;
      cycle(); idle();
   endtask

   task automatic query(logic [3:0] v, int r0, int r1, int r2, int r3);
      q_valid = v;
      q_regs = {5'(r3), 5'(r2), 5'(r1), 5'(r0)};
      cycle(); idle();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      nfails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state, an all-valid query on default mapping stalls nothing (capacities 0)
      q_valid = 4'hF; q_regs = {5'd3, 5'd2, 5'd1, 5'd0};
      #1;
      for (int f = 0; f < NF; f++) begin
         check("R1", $sformatf("reset used[%0d]", f), int'(used_flat[f*UW +: UW]), 0);
         check("R1", $sformatf("reset stall[%0d]", f), int'(stall[f]), 0);
      end
      check("R1", "reset count_err", int'(count_err), 0);
      idle();
      rst_n = 1;
      @(negedge clk);

      // R1: default map is file 0 cost 1
      cur_req = "R1"; alloc(10, 0, 0, 0);
      check("R1", "default cost on file 0", int'(used_flat[UW-1:0]), 1);
      release_reg(10, 0, 0, 0);

      // R12: capacities, then maps; query in the write cycle sees the old capacity
      cur_req = "R12";
      q_valid = 4'b0001; q_regs = '0;
      set_cap(0, 40);
      set_cap(1, 6);
      set_cap(2, 4);
      set_cap(3, 0);
      map_reg(1, 1, 1);
      map_reg(2, 1, 2);
      map_reg(3, 2, 1);
      map_reg(4, 3, 3);
      map_reg(5, 0, 2);
      map_reg(6, 2, 3);
      // R12: allocate in the same cycle that remaps it -> old entry (file 0, cost 1)
      cfg_map_we = 1; cfg_map_reg = 5'd9; cfg_map_file = 2'd2; cfg_map_cost = 3'd3;
      alloc_valid = 1; alloc_reg = 5'd9;
      cycle(); idle();
      check("R12", "old map used for file 2", int'(used_flat[2*UW +: UW]), 0);
      alloc(9, 0, 0, 0);
      check("R12", "new map used for file 2", int'(used_flat[2*UW +: UW]), 3);
      release_reg(9, 0, 0, 0);

      cur_req = "R2"; alloc(2, 0, 0, 0);
      check("R2", "file 1 after cost-2 allocate", int'(used_flat[UW +: UW]), 2);
      cur_req = "R3"; alloc(5, 0, 0, 0);
      check("R3", "file 1 unchanged by file-0 register", int'(used_flat[UW +: UW]), 2);
      release_reg(5, 0, 0, 0);

      cur_req = "R4";
      alloc(2, 1, 0, 0); alloc(2, 0, 1, 0); alloc(2, 0, 0, 1);
      release_reg(2, 1, 0, 0); release_reg(2, 0, 1, 0); release_reg(2, 0, 0, 1);
      check("R4", "file 1 untouched by qualified requests", int'(used_flat[UW +: UW]), 2);

      cur_req = "R5"; release_reg(2, 0, 0, 0);
      check("R5", "file 1 after release", int'(used_flat[UW +: UW]), 0);

      cur_req = "R6";
      alloc_valid = 1; alloc_reg = 5'd1; free_valid = 1; free_reg = 5'd1;
      cycle(); idle();
      check("R6", "covered release is not an underflow", int'(count_err), 0);
      alloc(5, 0, 0, 0);
      alloc_valid = 1; alloc_reg = 5'd3; free_valid = 1; free_reg = 5'd5;
      cycle(); idle();

      cur_req = "R8";
      alloc(4, 0, 0, 0); alloc(4, 0, 0, 0); alloc(4, 0, 0, 0);
      query(4'hF, 4, 4, 4, 4);

      cur_req = "R9";
      alloc(2, 0, 0, 0); alloc(2, 0, 0, 0);     // file 1 = 4 of 6
      query(4'b0011, 1, 2, 0, 0);               // need 3 -> stall file 1
      query(4'b0001, 1, 2, 0, 0);               // need 1 -> fits
      query(4'b1010, 2, 1, 2, 1);               // valid slots 1,3 -> need 2 -> fits
      query(4'b0101, 2, 1, 2, 1);               // need 4 -> stall
      query(4'b0000, 2, 2, 2, 2);

      cur_req = "R10";                          // file 2 holds 1 of 4
      query(4'b0011, 6, 6, 0, 0);               // need 6 trimmed to 4 -> stall
      release_reg(3, 0, 0, 0);
      query(4'b0011, 6, 6, 0, 0);               // trimmed, empty file -> fits

      cur_req = "R7";
      release_reg(6, 0, 0, 0);
      check("R7", "count_err after underflow", int'(count_err), 1);
      check("R7", "file 2 held at zero", int'(used_flat[2*UW +: UW]), 0);
      query(4'h1, 1, 0, 0, 0);
      alloc(1, 0, 0, 0);
      check("R7", "count_err stays set", int'(count_err), 1);

      cur_req = "R1";
      rst_n = 0;
      cycle();
      rst_n = 1;
      cycle();
      check("R1", "count_err cleared by reset", int'(count_err), 0);
      check("R1", "file 0 cleared by reset", int'(used_flat[UW-1:0]), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
      $finish;
   end

endmodule